// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block holds a short backlog of register writes that must land a fixed number of drain ticks after they are issued. A producer pushes an update into a ring of slots. Each update names a target register, a delay, a width (32 or 64 bits) and a kind: either a whole-register write or a single-bit set or clear. Every drain tick ages all waiting slots together. A slot whose delay runs out applies its update to a small internal register file in that same tick.

Slots can fire out of order because each has its own delay. They only leave the ring from the oldest end. A slot that has fired but still has an older, unfired slot in front of it keeps its place until the older one is gone. The register file is visible in full on a flat output bus. Occupancy, the oldest-slot pointer and the next-free pointer are also outputs.

Top module: `dlyupd_queue`

## Requirements
- R1: After reset every register reads zero, occupancy is zero, both pointers are zero, and the overflow and pointer-error flags are low.
- R2: An accepted enqueue raises occupancy by one and moves the tail pointer forward by one, modulo NSLOT (default 8).
- R3: An enqueue that finds the ring full, after any retirement in the same cycle, is dropped. enq_overflow is high for exactly the following cycle, and the ring and register file stay unchanged by it.
- R4: Each drain tick lowers the delay of every waiting slot together. A slot enqueued with delay d≥1 fires on the d-th drain tick after it was accepted. A delay of 0 fires on the first tick.
- R5: Bit mode (enq_bit_mode=1) sets bit enq_bit_pos when the value is nonzero over the active width, and clears it otherwise. The active width is the low 32 bits when enq_wide=0 and all 64 bits when enq_wide=1. With enq_wide=0 only the low 5 bits of the position are used.
- R6: Word mode (enq_bit_mode=0) replaces the register with the 64-bit value when enq_wide=1. When enq_wide=0 it writes the low 32 bits of the value and zero-fills bits 63:32.
- R7: When several slots fire in one tick, their updates apply oldest first, so the youngest whole write to a register wins and bit updates to one register accumulate.
- R8: Slots are freed only from the head. On a drain tick the head moves past every consecutive fired slot, so several can be freed at once. A fired slot behind an unfired one stays counted in occupancy.
- R9: When a drain tick and an enqueue arrive in the same cycle, retirement happens first. Space freed by that tick can take the new entry, and the new entry is not aged by that tick.
- R10: Without a drain tick, the register file and head pointer do not change.
- R11: ptr_err is high whenever occupancy is zero while head and tail differ. In normal operation it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drain_tick | input | 1 | Ages the waiting slots, fires those that are due, retires from the head |
| enq_valid | input | 1 | Enqueue request |
| enq_reg | input | RIDX_W | Target register index |
| enq_delay | input | DLY_W | Drain ticks until the update fires |
| enq_bit_mode | input | 1 | 1 = single-bit update, 0 = whole-register write |
| enq_bit_pos | input | 6 | Bit position for bit mode |
| enq_wide | input | 1 | 1 = 64-bit size, 0 = 32-bit size |
| enq_value | input | 64 | Update value |
| regs_flat | output | NREG*64 | Register r at bits [r*64 +: 64] |
| occupancy | output | CNT_W | Slots in use |
| head_ptr | output | PTR_W | Oldest slot index |
| tail_ptr | output | PTR_W | Next free slot index |
| enq_overflow | output | 1 | One-cycle pulse after a rejected enqueue |
| ptr_err | output | 1 | Pointer and occupancy disagree |

## Verification
The bench goes after slots that fire in a different order from the one in which they retire. A design that frees a fired slot away from the head would drop occupancy too early and let the tail overwrite a slot that is still live. It also targets two slots firing on the same register in one tick. Applying them newest first would leave the older value in the register, and dropping bit merges would lose one of two bit sets. Full-ring enqueues with and without a same-tick retirement are checked: reversing the order of drain and enqueue would wrongly reject the first case. Narrow writes that carry nonzero upper bits are checked too, which exposes missing zero-fill and a nonzero test taken over the wrong width.

// File: rtl/dlyupd_pkg.sv
package dlyupd_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned BPOS_W = 6;

  typedef logic [WORD_W-1:0] word_t;

  // Next value of a register after one update.
  function automatic word_t apply_update(input word_t cur, input logic bit_mode,
                                         input logic wide, input logic [BPOS_W-1:0] bpos,
                                         input word_t val);
    word_t             res;
    logic [BPOS_W-1:0] pos;
    logic              nz;
    res = cur;
    nz  = wide ? (|val) : (|val[HALF_W-1:0]);
    pos = wide ? bpos : {1'b0, bpos[BPOS_W-2:0]};
    if (bit_mode) res[pos] = nz;
    else if (wide) res = val;
    else res = {{HALF_W{1'b0}}, val[HALF_W-1:0]};
    return res;
  endfunction

  // Ring index arithmetic; p < depth and n <= depth.
  function automatic int unsigned ring_add(input int unsigned p, input int unsigned n,
                                           input int unsigned depth);
    int unsigned s;
    s = p + n;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/dlyupd_slots.sv
module dlyupd_slots
  import dlyupd_pkg::*;
#(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned DLY_W  = 4,
  parameter int unsigned RIDX_W = 2,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drain_tick,
  input  logic              enq_valid,
  input  logic [RIDX_W-1:0] enq_reg,
  input  logic [DLY_W-1:0]  enq_delay,
  input  logic              enq_bit_mode,
  input  logic [BPOS_W-1:0] enq_bit_pos,
  input  logic              enq_wide,
  input  word_t             enq_value,
  output logic [NSLOT-1:0]  fire_vec,
  output logic [RIDX_W-1:0] sl_reg  [NSLOT],
  output logic [NSLOT-1:0]  sl_mode,
  output logic [NSLOT-1:0]  sl_wide,
  output logic [BPOS_W-1:0] sl_bpos [NSLOT],
  output word_t             sl_val  [NSLOT],
  output logic [PTR_W-1:0]  head,
  output logic [PTR_W-1:0]  tail,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic [CNT_W-1:0]  ret_cnt,
  output logic              enq_accept
);

  logic [NSLOT-1:0] valid;
  logic [NSLOT-1:0] fired;
  logic [DLY_W-1:0] dly [NSLOT];
  logic [NSLOT-1:0] due;
  logic [NSLOT-1:0] done;
  logic [NSLOT-1:0] ret_mask;
  logic [CNT_W-1:0] cnt_after;

  generate
    for (genvar k = 0; k < NSLOT; k++) begin : g_due
      assign due[k] = (dly[k] <= DLY_W'(1));
    end
  endgenerate

  assign fire_vec = {NSLOT{drain_tick}} & valid & ~fired & due;
  assign done     = valid & (fired | fire_vec);

  // Walk from the head and free the run of fired slots.
  always_comb begin
    logic             run;
    logic [PTR_W-1:0] idx;
    run      = 1'b1;
    ret_cnt  = '0;
    ret_mask = '0;
    for (int i = 0; i < NSLOT; i++) begin
      idx = PTR_W'(ring_add(32'(head), 32'(i), NSLOT));
      if (run && drain_tick && (CNT_W'(i) < count) && done[idx]) begin
        ret_mask[idx] = 1'b1;
        ret_cnt       = ret_cnt + CNT_W'(1);
      end else begin
        run = 1'b0;
      end
    end
  end

  assign cnt_after  = count - ret_cnt;
  assign enq_accept = enq_valid && (cnt_after < CNT_W'(NSLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      fired <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      for (int k = 0; k < NSLOT; k++) dly[k] <= '0;
    end else begin
      head  <= PTR_W'(ring_add(32'(head), 32'(ret_cnt), NSLOT));
      count <= cnt_after + CNT_W'(enq_accept);
      ovf   <= enq_valid && !enq_accept;
      if (enq_accept) tail <= PTR_W'(ring_add(32'(tail), 32'd1, NSLOT));
      for (int k = 0; k < NSLOT; k++) begin
        if (ret_mask[k]) begin
          valid[k] <= 1'b0;
          fired[k] <= 1'b0;
        end else if (fire_vec[k]) begin
          fired[k] <= 1'b1;
        end else if (drain_tick && valid[k] && !fired[k]) begin
          dly[k] <= dly[k] - DLY_W'(1);
        end
      end
      if (enq_accept) begin
        valid[tail] <= 1'b1;
        fired[tail] <= 1'b0;
        dly[tail]   <= enq_delay;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_mode <= '0;
      sl_wide <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        sl_reg[k]  <= '0;
        sl_bpos[k] <= '0;
        sl_val[k]  <= '0;
      end
    end else if (enq_accept) begin
      sl_reg[tail]  <= enq_reg;
      sl_mode[tail] <= enq_bit_mode;
      sl_wide[tail] <= enq_wide;
      sl_bpos[tail] <= enq_bit_pos;
      sl_val[tail]  <= enq_value;
    end
  end

endmodule

// File: rtl/dlyupd_merge.sv
module dlyupd_merge
  import dlyupd_pkg::*;
#(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned NREG   = 4,
  parameter int unsigned RIDX_W = 2,
  parameter int unsigned PTR_W  = 3
) (
  input  logic [PTR_W-1:0]  head,
  input  logic [NSLOT-1:0]  fire_vec,
  input  logic [RIDX_W-1:0] sl_reg  [NSLOT],
  input  logic [NSLOT-1:0]  sl_mode,
  input  logic [NSLOT-1:0]  sl_wide,
  input  logic [BPOS_W-1:0] sl_bpos [NSLOT],
  input  word_t             sl_val  [NSLOT],
  input  word_t             cur_regs [NREG],
  output word_t             nxt_regs [NREG],
  output logic [NREG-1:0]   wr_en
);

  // Fold the firing slots into each register, oldest first.
  always_comb begin
    word_t            acc;
    logic             hit;
    logic [PTR_W-1:0] idx;
    for (int r = 0; r < NREG; r++) begin
      acc = cur_regs[r];
      hit = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        idx = PTR_W'(ring_add(32'(head), 32'(i), NSLOT));
        if (fire_vec[idx] && (sl_reg[idx] == RIDX_W'(r))) begin
          acc = apply_update(acc, sl_mode[idx], sl_wide[idx], sl_bpos[idx], sl_val[idx]);
          hit = 1'b1;
        end
      end
      nxt_regs[r] = acc;
      wr_en[r]    = hit;
    end
  end

endmodule

// File: rtl/dlyupd_regfile.sv
module dlyupd_regfile
  import dlyupd_pkg::*;
#(
  parameter int unsigned NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] wr_en,
  input  word_t           nxt_regs [NREG],
  output word_t           regs     [NREG]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en[r]) regs[r] <= nxt_regs[r];
      end
    end
  end

endmodule

// File: rtl/dlyupd_queue.sv
module dlyupd_queue
  import dlyupd_pkg::*;
#(
  parameter  int unsigned NSLOT  = 8,
  parameter  int unsigned NREG   = 4,
  parameter  int unsigned DLY_W  = 4,
  localparam int unsigned RIDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned PTR_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int unsigned CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   drain_tick,
  input  logic                   enq_valid,
  input  logic [RIDX_W-1:0]      enq_reg,
  input  logic [DLY_W-1:0]       enq_delay,
  input  logic                   enq_bit_mode,
  input  logic [5:0]             enq_bit_pos,
  input  logic                   enq_wide,
  input  logic [63:0]            enq_value,
  output logic [NREG*WORD_W-1:0] regs_flat,
  output logic [CNT_W-1:0]       occupancy,
  output logic [PTR_W-1:0]       head_ptr,
  output logic [PTR_W-1:0]       tail_ptr,
  output logic                   enq_overflow,
  output logic                   ptr_err
);

  logic [NSLOT-1:0]  fire_vec;
  logic [RIDX_W-1:0] sl_reg  [NSLOT];
  logic [NSLOT-1:0]  sl_mode;
  logic [NSLOT-1:0]  sl_wide;
  logic [BPOS_W-1:0] sl_bpos [NSLOT];
  word_t             sl_val  [NSLOT];
  logic [CNT_W-1:0]  ret_cnt;
  logic              enq_accept;
  word_t             regs     [NREG];
  word_t             nxt_regs [NREG];
  logic [NREG-1:0]   wr_en;

  dlyupd_slots #(
    .NSLOT(NSLOT), .DLY_W(DLY_W), .RIDX_W(RIDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) slots_i (
    .clk(clk), .rst_n(rst_n), .drain_tick(drain_tick), .enq_valid(enq_valid),
    .enq_reg(enq_reg), .enq_delay(enq_delay), .enq_bit_mode(enq_bit_mode),
    .enq_bit_pos(enq_bit_pos), .enq_wide(enq_wide), .enq_value(enq_value),
    .fire_vec(fire_vec), .sl_reg(sl_reg), .sl_mode(sl_mode), .sl_wide(sl_wide),
    .sl_bpos(sl_bpos), .sl_val(sl_val), .head(head_ptr), .tail(tail_ptr),
    .count(occupancy), .ovf(enq_overflow), .ret_cnt(ret_cnt), .enq_accept(enq_accept)
  );

  dlyupd_merge #(
    .NSLOT(NSLOT), .NREG(NREG), .RIDX_W(RIDX_W), .PTR_W(PTR_W)
  ) merge_i (
    .head(head_ptr), .fire_vec(fire_vec), .sl_reg(sl_reg), .sl_mode(sl_mode),
    .sl_wide(sl_wide), .sl_bpos(sl_bpos), .sl_val(sl_val), .cur_regs(regs),
    .nxt_regs(nxt_regs), .wr_en(wr_en)
  );

  dlyupd_regfile #(.NREG(NREG)) regfile_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .nxt_regs(nxt_regs), .regs(regs)
  );

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_flat
      assign regs_flat[r*WORD_W +: WORD_W] = regs[r];
    end
  endgenerate

  assign ptr_err = (occupancy == '0) && (head_ptr != tail_ptr);

endmodule

// File: rtl/dlyupd_chk.sv
module dlyupd_chk #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned NREG  = 4,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                drain_tick,
  input logic                enq_valid,
  input logic [NREG*64-1:0]  regs_flat,
  input logic [CNT_W-1:0]    occupancy,
  input logic [PTR_W-1:0]    head_ptr,
  input logic [PTR_W-1:0]    tail_ptr,
  input logic                enq_overflow,
  input logic                ptr_err,
  input logic [NSLOT-1:0]    fire_vec,
  input logic [CNT_W-1:0]    ret_cnt,
  input logic                enq_accept
);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(NSLOT)); // R2

  AST_ACCEPT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    enq_accept |=> (tail_ptr != $past(tail_ptr))); // R2

  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_accept && !drain_tick) |=> (occupancy == $past(occupancy) + CNT_W'(1))); // R2

  AST_REJECT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !drain_tick && occupancy == CNT_W'(NSLOT)) |=>
      (enq_overflow && occupancy == CNT_W'(NSLOT))); // R3

  AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec != '0) |-> drain_tick); // R4

  AST_RETIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cnt != '0) |-> drain_tick); // R8

  AST_RETIRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ret_cnt <= occupancy); // R8

  AST_IDLE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_tick |=> $stable(head_ptr)); // R10

  AST_IDLE_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_tick |=> $stable(regs_flat)); // R10

  AST_NO_PTR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_err); // R11

endmodule

bind dlyupd_queue dlyupd_chk #(
  .NSLOT(NSLOT), .NREG(NREG), .PTR_W(PTR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .drain_tick(drain_tick), .enq_valid(enq_valid),
  .regs_flat(regs_flat), .occupancy(occupancy), .head_ptr(head_ptr),
  .tail_ptr(tail_ptr), .enq_overflow(enq_overflow), .ptr_err(ptr_err),
  .fire_vec(fire_vec), .ret_cnt(ret_cnt), .enq_accept(enq_accept)
);

// File: tb/dlyupd_queue_tb_top.sv
module dlyupd_queue_tb_top;

  localparam int NS = 8;
  localparam int NR = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         drain_tick = 1'b0;
  logic         enq_valid = 1'b0;
  logic [1:0]   enq_reg = '0;
  logic [3:0]   enq_delay = '0;
  logic         enq_bit_mode = 1'b0;
  logic [5:0]   enq_bit_pos = '0;
  logic         enq_wide = 1'b0;
  logic [63:0]  enq_value = '0;
  logic [255:0] regs_flat;
  logic [3:0]   occupancy;
  logic [2:0]   head_ptr;
  logic [2:0]   tail_ptr;
  logic         enq_overflow;
  logic         ptr_err;

  always #4 clk = ~clk;

  dlyupd_queue dut_i (
    .clk(clk), .rst_n(rst_n), .drain_tick(drain_tick), .enq_valid(enq_valid),
    .enq_reg(enq_reg), .enq_delay(enq_delay), .enq_bit_mode(enq_bit_mode),
    .enq_bit_pos(enq_bit_pos), .enq_wide(enq_wide), .enq_value(enq_value),
    .regs_flat(regs_flat), .occupancy(occupancy), .head_ptr(head_ptr),
    .tail_ptr(tail_ptr), .enq_overflow(enq_overflow), .ptr_err(ptr_err)
  );

  typedef struct {
    int          r;
    int          d;
    bit          kind;
    int          bp;
    logic [63:0] v;
    bit          wide;
    bit          fired;
  } ent_t;

  ent_t        q[$];
  logic [63:0] m_regs [NR];
  int          m_head = 0;
  bit          m_ovf = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done_flag = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_apply(input logic [63:0] cur, input ent_t e);
    logic [63:0] lo;
    int          p;
    bit          on;
    lo = {32'h0, e.v[31:0]};
    if (e.kind) begin
      p  = e.wide ? e.bp : (e.bp % 32);
      on = e.wide ? (e.v != 0) : (lo != 0);
      cur[p] = on;
    end else begin
      cur = e.wide ? e.v : lo;
    end
    return cur;
  endfunction

  task automatic model_edge(input bit dr, input bit en, input ent_t e);
    m_ovf = 0;
    if (dr) begin
      foreach (q[i]) begin
        if (!q[i].fired) begin
          if (q[i].d <= 1) begin
            m_regs[q[i].r] = ref_apply(m_regs[q[i].r], q[i]);
            q[i].fired = 1;
          end else begin
            q[i].d = q[i].d - 1;
          end
        end
      end
      while (q.size() > 0 && q[0].fired) begin
        void'(q.pop_front());
        m_head = (m_head + 1) % NS;
      end
    end
    if (en) begin
      if (q.size() == NS) m_ovf = 1;
      else q.push_back(e);
    end
  endtask

  task automatic compare(input string tag);
    chk("R2", "occupancy", 64'(occupancy), 64'(q.size()));
    chk("R2", "tail_ptr", 64'(tail_ptr), 64'((m_head + q.size()) % NS));
    chk("R8", "head_ptr", 64'(head_ptr), 64'(m_head));
    chk("R3", "enq_overflow", 64'(enq_overflow), 64'(m_ovf));
    chk("R11", "ptr_err", 64'(ptr_err), 64'd0);
    for (int r = 0; r < NR; r++) chk(tag, "reg", regs_flat[r*64 +: 64], m_regs[r]);
  endtask

  task automatic step(input bit dr, input bit en, input int r, input int d, input bit kind,
                      input int bp, input logic [63:0] v, input bit wide, input string tag);
    ent_t e;
    e.r = r; e.d = d; e.kind = kind; e.bp = bp; e.v = v; e.wide = wide; e.fired = 0;
    drain_tick   = dr;
    enq_valid    = en;
    enq_reg      = 2'(r);
    enq_delay    = 4'(d);
    enq_bit_mode = kind;
    enq_bit_pos  = 6'(bp);
    enq_wide     = wide;
    enq_value    = v;
    @(posedge clk);
    model_edge(dr, en, e);
    @(negedge clk);
    drain_tick = 0;
    enq_valid  = 0;
    compare(tag);
  endtask

  task automatic put(input int r, input int d, input bit kind, input int bp,
                     input logic [63:0] v, input bit wide, input string tag);
    step(0, 1, r, d, kind, bp, v, wide, tag);
  endtask

  task automatic tick(input string tag);
    step(1, 0, 0, 0, 0, 0, 64'h0, 0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 64'h0, 0, tag);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) m_regs[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    compare("R1");
    chk("R1", "head_ptr", 64'(head_ptr), 64'd0);

    // R6: whole 64-bit write
    put(0, 1, 0, 0, 64'h1122_3344_5566_7788, 1, "R2");
    tick("R6");
    chk("R6", "reg0", regs_flat[0 +: 64], 64'h1122_3344_5566_7788);

    // R6: narrow write zero-fills the upper half
    put(1, 1, 0, 0, 64'hFFFF_0000_89AB_CDEF, 0, "R6");
    tick("R6");
    chk("R6", "reg1", regs_flat[64 +: 64], 64'h0000_0000_89AB_CDEF);

    // R4, R10: delay 3 with idle cycles in between
    put(2, 3, 0, 0, 64'hA5A5_5A5A_0F0F_F0F0, 1, "R4");
    tick("R4");
    idle(2, "R10");
    tick("R4");
    chk("R4", "reg2 before due", regs_flat[128 +: 64], 64'h0);
    tick("R4");
    chk("R4", "reg2 after due", regs_flat[128 +: 64], 64'hA5A5_5A5A_0F0F_F0F0);

    // R4: delay zero fires on the first tick
    put(3, 0, 0, 0, 64'h0000_0000_0000_1234, 1, "R4");
    tick("R4");
    chk("R4", "reg3 delay0", regs_flat[192 +: 64], 64'h1234);

    // R5: wide bit set, narrow bit clear with position folded to 5 bits
    put(0, 1, 1, 63, 64'h1, 1, "R5");
    tick("R5");
    put(0, 1, 1, 35, 64'h0000_0001_0000_0000, 0, "R5");
    tick("R5");
    chk("R5", "reg0 bits", regs_flat[0 +: 64], 64'h9122_3344_5566_7780);

    // R8: younger slot fires first but the head waits
    put(1, 5, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA, 1, "R8");
    put(2, 1, 0, 0, 64'hBBBB_BBBB_BBBB_BBBB, 1, "R8");
    tick("R8");
    chk("R8", "occupancy held", 64'(occupancy), 64'd2);
    for (int i = 0; i < 4; i++) tick("R8");
    chk("R8", "both retired", 64'(occupancy), 64'd0);

    // R7: same-tick collisions, youngest whole write wins, bit sets merge
    put(3, 1, 0, 0, 64'hCCCC_CCCC_CCCC_CCCC, 1, "R7");
    put(3, 1, 0, 0, 64'hDDDD_DDDD_DDDD_DDDD, 0, "R7");
    tick("R7");
    chk("R7", "reg3 youngest", regs_flat[192 +: 64], 64'h0000_0000_DDDD_DDDD);
    put(2, 1, 1, 0, 64'h0, 1, "R7");
    put(2, 1, 1, 4, 64'h0, 1, "R7");
    put(2, 1, 1, 0, 64'h5, 1, "R7");
    tick("R7");

    // R9: enqueue and drain together; new entry is not aged that tick
    step(1, 1, 0, 2, 0, 0, 64'h77, 1, "R9");
    tick("R9");
    chk("R9", "not yet fired", regs_flat[0 +: 64], m_regs[0]);
    tick("R9");

    // R3, R9: fill the ring, reject, then accept on a freeing tick
    for (int i = 0; i < NS; i++) put(1, 9, 0, 0, 64'(i + 100), 1, "R2");
    put(2, 1, 0, 0, 64'hEE, 1, "R3");
    chk("R3", "overflow pulse", 64'(enq_overflow), 64'd1);
    idle(1, "R3");
    chk("R3", "overflow clears", 64'(enq_overflow), 64'd0);
    step(1, 1, 2, 1, 0, 0, 64'hEF, 1, "R9");
    chk("R9", "full no free", 64'(enq_overflow), 64'd1);
    for (int i = 0; i < 7; i++) tick("R4");
    step(1, 1, 2, 1, 0, 0, 64'hF00D, 1, "R9");
    chk("R9", "freed then accepted", 64'(occupancy), 64'd1);
    chk("R9", "no overflow", 64'(enq_overflow), 64'd0);
    tick("R9");

    // Mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      bit          dr;
      bit          en;
      logic [63:0] v;
      dr = ($urandom % 2) == 0;
      en = ($urandom % 3) != 0;
      v  = {32'($urandom), 32'($urandom)};
      if (($urandom % 5) == 0) v = '0;
      if (($urandom % 5) == 0) v = {v[63:32], 32'h0};
      step(dr, en, int'($urandom % NR), int'($urandom % 6), 1'($urandom), int'($urandom % 64),
           v, 1'($urandom), "R7");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule